// File: doc/BRIEF.md
# Slave-mode serial audio transmitter

This block sends 16-bit audio samples over a three-wire serial audio link on which it is the slave. An external master drives the bit clock and the word-select line. Both inputs pass through synchronizers into the system clock, and all the logic runs in that domain. Samples come in through a valid/ready stream into a single-entry holding buffer. At the start of each channel slot the buffer is copied into a 16-bit shift register, which drives the serial data pin MSB first.

Framing uses a one-bit delay. The master changes word-select together with the last bit of a slot. The slave takes the new level on the next rising bit-clock edge and drives the MSB of the new slot on the falling edge after that. Word-select low selects the left channel, and high selects the right. Transmission always begins with a left slot. If a slot begins while the buffer is empty, the block flags an underrun, goes silent, and resumes only at a later left slot once software has cleared the flag.

Back-pressure on the sample stream: `s_ready` is high only while the block is enabled and the buffer is empty. A sample is taken in a cycle where both `s_valid` and `s_ready` are high. `s_valid` may be held for any length of time, and nothing is lost while `s_ready` is low.

Top module: `i2s_slave_tx`

## Requirements
- R1: After reset, `txe`=1, `busy`=0, `udr`=0, `sd_o`=0, `s_ready`=0, `irq`=0 and `chside`=1 (right).
- R2: `s_ready` equals `en` AND buffer empty. An accepted sample makes `txe` 0 in the next cycle. While `en` is 0, no sample is accepted.
- R3: With a sample buffered, a slot start with word-select high (right) does not begin transmission. The first load happens at a slot start with word-select low (left). `chside` reports the current slot's side: 0 for left, 1 for right.
- R4: Each loaded sample appears on `sd_o` as 16 bits, MSB first. Data changes after falling bit-clock edges, and the master samples it on rising edges. The MSB comes in the bit period after the one in which word-select changed.
- R5: When the buffer moves into the shift register, `txe` returns to 1.
- R6: A slot start that finds the buffer empty while transmitting sets `udr`. While `udr` is 1, `sd_o` is 0 and `busy` is 0.
- R7: `udr` stays 1 until a one-cycle pulse on `udr_clr` clears it. While it is set, no slot loads a sample, but a sample may still be written, and that write makes `txe` 0.
- R8: After `udr` is cleared, a buffered sample is not sent in a right slot. It is loaded at the next left slot start.
- R9: `irq` = (`txe_ie` AND `txe` AND `en`) OR (`err_ie` AND `udr`).
- R10: One cycle after `en` is 0, `txe`=1, `busy`=0 and `sd_o`=0, and the buffer is discarded.
- R11: `busy` rises at the first load. It stays high while the buffer is empty and bits of the slot remain. It falls once the slot's last bit has been sampled and the buffer is still empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Transmitter enable |
| txe_ie | input | 1 | Interrupt enable for buffer empty |
| err_ie | input | 1 | Interrupt enable for underrun |
| udr_clr | input | 1 | One-cycle pulse that clears the underrun flag |
| s_valid | input | 1 | Sample stream valid |
| s_data | input | 16 | Sample stream data |
| s_ready | output | 1 | Sample stream ready (enabled and buffer empty) |
| sck_i | input | 1 | Bit clock from the external master |
| ws_i | input | 1 | Word-select from the external master (0 left, 1 right) |
| sd_o | output | 1 | Serial data out |
| chside | output | 1 | Side of the current slot (0 left, 1 right) |
| txe | output | 1 | Buffer empty flag |
| busy | output | 1 | Transmission in progress |
| udr | output | 1 | Sticky underrun flag |
| irq | output | 1 | Combined interrupt request |

## Verification
Results that depend on the bit clock are due three system clocks after the input edge: two synchronizer flops and one action register. The bench holds each bit-clock phase for eight system clocks and samples `sd_o` on the rising bit-clock edge, so every driven bit has settled before it is read. Flag results (`txe`, `busy`, `udr`, `chside`, `irq`) are read at the end of a run of bit periods or on the falling system-clock edge after a stream write. By then each flag has had at least one register update since its cause. Disable and accept effects are checked exactly one system clock after the input changes.

// File: rtl/i2s_tx_pkg.sv
package i2s_tx_pkg;
  typedef enum logic {
    SIDE_LEFT  = 1'b0,
    SIDE_RIGHT = 1'b1
  } side_e;
endpackage

// File: rtl/i2s_tx_sync.sv
// Multi-bit level synchronizer with edge detection on the synchronized output.
module i2s_tx_sync #(
  parameter int           WIDTH   = 2,
  parameter int           STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] level,
  output logic [WIDTH-1:0] rise,
  output logic [WIDTH-1:0] fall
);
  logic [WIDTH-1:0] prev;

  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL[g]}};
      else        chain <= {chain[STAGES-2:0], din[g]};
    end
    assign level[g] = chain[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= RST_VAL;
    else        prev <= level;
  end

  assign rise = level & ~prev;
  assign fall = ~level & prev;
endmodule

// File: rtl/i2s_tx_buffer.sv
// Single-entry sample holding buffer with a valid/ready write side.
module i2s_tx_buffer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         wr_valid,
  input  logic [W-1:0] wr_data,
  output logic         wr_ready,
  input  logic         take,
  output logic         full,
  output logic [W-1:0] data
);
  assign wr_ready = en && !full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full <= 1'b0;
      data <= '0;
    end else if (!en) begin
      full <= 1'b0;
    end else if (wr_valid && wr_ready) begin
      full <= 1'b1;
      data <= wr_data;
    end else if (take) begin
      full <= 1'b0;
    end
  end
endmodule

// File: rtl/i2s_tx_serializer.sv
// Slot tracking, shift register, bit counting and underrun detection.
module i2s_tx_serializer
  import i2s_tx_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         sck_rise,
  input  logic         sck_fall,
  input  logic         ws_lvl,
  input  logic         buf_full,
  input  logic [W-1:0] buf_data,
  input  logic         udr_clr,
  output logic         take,
  output logic         sd,
  output logic         active,
  output logic         last_done,
  output logic         udr,
  output side_e        side
);
  localparam int CW = $clog2(W + 1);
  localparam logic [CW-1:0] LAST = CW'(W);

  logic         ws_r;
  logic [W-1:0] shreg;
  logic [CW-1:0] cnt;
  logic         slot_start, start_ok, miss;

  assign slot_start = sck_fall && (ws_r != side);
  assign start_ok   = slot_start && en && !udr && buf_full &&
                      (active || side_e'(ws_r) == SIDE_LEFT);
  assign miss       = slot_start && en && active && !buf_full;
  assign take       = start_ok;
  assign sd         = shreg[W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ws_r <= 1'b1;
      side <= SIDE_RIGHT;
    end else begin
      if (sck_rise)   ws_r <= ws_lvl;
      if (slot_start) side <= side_e'(ws_r);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active    <= 1'b0;
      shreg     <= '0;
      cnt       <= '0;
      last_done <= 1'b0;
    end else if (!en || miss) begin
      active    <= 1'b0;
      shreg     <= '0;
      cnt       <= '0;
      last_done <= 1'b0;
    end else if (start_ok) begin
      active    <= 1'b1;
      shreg     <= buf_data;
      cnt       <= CW'(1);
      last_done <= 1'b0;
    end else begin
      if (sck_fall && active) begin
        shreg <= {shreg[W-2:0], 1'b0};
        if (cnt != LAST) cnt <= cnt + CW'(1);
      end
      if (sck_rise && active && cnt == LAST) last_done <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       udr <= 1'b0;
    else if (miss)    udr <= 1'b1;
    else if (udr_clr) udr <= 1'b0;
  end
endmodule

// File: rtl/i2s_slave_tx.sv
module i2s_slave_tx
  import i2s_tx_pkg::*;
#(
  parameter int SAMPLE_W    = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic                txe_ie,
  input  logic                err_ie,
  input  logic                udr_clr,
  input  logic                s_valid,
  input  logic [SAMPLE_W-1:0] s_data,
  output logic                s_ready,
  input  logic                sck_i,
  input  logic                ws_i,
  output logic                sd_o,
  output logic                chside,
  output logic                txe,
  output logic                busy,
  output logic                udr,
  output logic                irq
);
  logic [1:0] lvl, rise, fall;
  logic       buf_full, take, active, last_done;
  logic [SAMPLE_W-1:0] buf_data;
  side_e      side;

  i2s_tx_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync (
    .clk(clk), .rst_n(rst_n), .din({ws_i, sck_i}),
    .level(lvl), .rise(rise), .fall(fall)
  );

  i2s_tx_buffer #(.W(SAMPLE_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .en(en),
    .wr_valid(s_valid), .wr_data(s_data), .wr_ready(s_ready),
    .take(take), .full(buf_full), .data(buf_data)
  );

  i2s_tx_serializer #(.W(SAMPLE_W)) u_ser (
    .clk(clk), .rst_n(rst_n), .en(en),
    .sck_rise(rise[0]), .sck_fall(fall[0]), .ws_lvl(lvl[1]),
    .buf_full(buf_full), .buf_data(buf_data), .udr_clr(udr_clr),
    .take(take), .sd(sd_o), .active(active), .last_done(last_done),
    .udr(udr), .side(side)
  );

  assign chside = (side == SIDE_RIGHT);
  assign txe    = !buf_full;
  assign busy   = active && !(last_done && !buf_full);
  assign irq    = (txe_ie && txe && en) || (err_ie && udr);
endmodule

// File: rtl/i2s_slave_tx_checker.sv
module i2s_slave_tx_checker (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic s_valid,
  input logic s_ready,
  input logic udr_clr,
  input logic txe,
  input logic busy,
  input logic udr,
  input logic sd_o
);
  a_r2_accept_clears_txe: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready) |=> !txe);

  a_r2_no_accept_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !s_ready);

  a_r6_underrun_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    udr |-> (!sd_o && !busy));

  a_r7_underrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (udr && !udr_clr) |=> udr);

  a_r10_disable_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (txe && !busy && !sd_o));
endmodule

bind i2s_slave_tx i2s_slave_tx_checker u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .s_valid(s_valid), .s_ready(s_ready),
  .udr_clr(udr_clr), .txe(txe), .busy(busy), .udr(udr), .sd_o(sd_o)
);

// File: tb/i2s_slave_tx_bench.sv
module i2s_slave_tx_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HALF_BIT   = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0, txe_ie = 1'b0, err_ie = 1'b0, udr_clr = 1'b0;
  logic        s_valid = 1'b0;
  logic [15:0] s_data = '0;
  logic        sck_i = 1'b1, ws_i = 1'b1;
  logic        s_ready, sd_o, chside, txe, busy, udr, irq;

  int checks = 0, fails = 0;
  bit finished = 0;
  bit mon_on = 0;
  logic [16:0] exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  i2s_slave_tx u_i2s_slave_tx (
    .clk(clk), .rst_n(rst_n), .en(en), .txe_ie(txe_ie), .err_ie(err_ie),
    .udr_clr(udr_clr), .s_valid(s_valid), .s_data(s_data), .s_ready(s_ready),
    .sck_i(sck_i), .ws_i(ws_i), .sd_o(sd_o), .chside(chside), .txe(txe),
    .busy(busy), .udr(udr), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic flag(input string req, input logic act, input logic exp);
    chk(act === exp, req, {31'd0, act}, {31'd0, exp});
  endtask

  // Driver side of the scoreboard: expected slot contents {side, word}.
  task automatic expect_slot(input logic side, input logic [15:0] w);
    exp_q.push_back({side, w});
  endtask

  task automatic write_sample(input logic [15:0] v, input logic exp_ready, input string req);
    logic got;
    @(negedge clk);
    got = s_ready;
    flag(req, got, exp_ready);
    s_valid = 1'b1;
    s_data  = v;
    @(negedge clk);
    s_valid = 1'b0;
  endtask

  task automatic run_bits(input logic ws_val, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      sck_i = 1'b0;
      ws_i  = ws_val;
      repeat (HALF_BIT) @(negedge clk);
      sck_i = 1'b1;
      repeat (HALF_BIT) @(negedge clk);
    end
  endtask

  // Monitor: collects each slot's 16 bits at rising bit-clock edges (R4).
  logic        prev_ws = 1'b1, slot_ws = 1'b1, collecting = 1'b0;
  int          nbits = 0;
  logic [15:0] word = '0;
  always @(posedge sck_i) begin
    logic [16:0] e;
    if (prev_ws != slot_ws) begin
      slot_ws    = prev_ws;
      nbits      = 0;
      word       = '0;
      collecting = mon_on;
    end
    if (collecting && nbits < 16) begin
      word  = {word[14:0], sd_o};
      nbits = nbits + 1;
      if (nbits == 16) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R4 unexpected slot", {15'd0, slot_ws, word}, 32'hFFFF_FFFF);
        end else begin
          e = exp_q.pop_front();
          chk({slot_ws, word} === e, "R4 slot data", {15'd0, slot_ws, word}, {15'd0, e});
        end
      end
    end
    prev_ws = ws_i;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    flag("R1 txe", txe, 1'b1);
    flag("R1 busy", busy, 1'b0);
    flag("R1 udr", udr, 1'b0);
    flag("R1 sd_o", sd_o, 1'b0);
    flag("R1 s_ready", s_ready, 1'b0);
    flag("R1 irq", irq, 1'b0);
    flag("R1 chside", chside, 1'b1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R2: writes ignored while disabled
    write_sample(16'hDEAD, 1'b0, "R2 ready while disabled");
    flag("R2 txe after ignored write", txe, 1'b1);

    // Put the slave on a left slot while disabled, then enable
    run_bits(1'b0, 4);
    en = 1'b1; err_ie = 1'b1;
    write_sample(16'hA5C3, 1'b1, "R2 ready when enabled");
    flag("R2 txe after accept", txe, 1'b0);
    flag("R2 ready while full", s_ready, 1'b0);

    // R3: a right slot start does not begin transmission
    run_bits(1'b1, 16);
    flag("R3 no start on right", busy, 1'b0);
    flag("R3 chside right", chside, 1'b1);
    flag("R3 sample kept", txe, 1'b0);

    // Left slot starts transmission
    mon_on = 1'b1;
    expect_slot(1'b0, 16'hA5C3);
    run_bits(1'b0, 16);
    flag("R3 chside left", chside, 1'b0);
    flag("R11 busy after load", busy, 1'b1);
    flag("R5 txe after load", txe, 1'b1);
    flag("R9 irq masked", irq, 1'b0);
    txe_ie = 1'b1;
    @(negedge clk);
    flag("R9 irq on txe", irq, 1'b1);
    expect_slot(1'b1, 16'h1234);
    write_sample(16'h1234, 1'b1, "R2 ready after load");
    flag("R9 irq off when full", irq, 1'b0);

    run_bits(1'b1, 16);
    expect_slot(1'b0, 16'h8001);
    write_sample(16'h8001, 1'b1, "R5 right buffer moved");
    run_bits(1'b0, 16);
    expect_slot(1'b1, 16'h7FFE);
    write_sample(16'h7FFE, 1'b1, "R5 left buffer moved");
    run_bits(1'b1, 16);
    flag("R11 busy with bits left", busy, 1'b1);
    flag("R6 no underrun yet", udr, 1'b0);

    // LSB period: then busy drops with empty buffer
    expect_slot(1'b0, 16'h0000);
    run_bits(1'b0, 1);
    flag("R11 busy after last bit", busy, 1'b0);
    run_bits(1'b0, 15);
    flag("R6 underrun set", udr, 1'b1);
    flag("R6 sd quiet", sd_o, 1'b0);
    flag("R9 irq on error", irq, 1'b1);

    // R7: write accepted during underrun, not loaded
    txe_ie = 1'b0;
    write_sample(16'h5AA5, 1'b1, "R7 ready during underrun");
    flag("R7 txe cleared by write", txe, 1'b0);
    expect_slot(1'b1, 16'h0000);
    expect_slot(1'b0, 16'h0000);
    run_bits(1'b1, 16);
    run_bits(1'b0, 16);
    flag("R7 udr sticky", udr, 1'b1);
    flag("R7 no load in underrun", txe, 1'b0);
    @(negedge clk); udr_clr = 1'b1;
    @(negedge clk); udr_clr = 1'b0;
    flag("R7 udr cleared", udr, 1'b0);
    flag("R9 irq after clear", irq, 1'b0);

    // R8: restart waits for a left slot
    expect_slot(1'b1, 16'h0000);
    run_bits(1'b1, 16);
    flag("R8 no restart on right", busy, 1'b0);
    expect_slot(1'b0, 16'h5AA5);
    run_bits(1'b0, 16);
    flag("R8 restart on left", busy, 1'b1);
    expect_slot(1'b1, 16'h0F0F);
    write_sample(16'h0F0F, 1'b1, "R8 ready after restart");
    run_bits(1'b1, 16);
    run_bits(1'b0, 1);
    mon_on = 1'b0;
    chk(exp_q.size() == 0, "R4 all slots seen", exp_q.size(), 0);

    // R10: disable
    txe_ie = 1'b1;
    @(negedge clk); en = 1'b0;
    @(negedge clk);
    flag("R10 txe", txe, 1'b1);
    flag("R10 busy", busy, 1'b0);
    flag("R10 sd_o", sd_o, 1'b0);
    flag("R10 s_ready", s_ready, 1'b0);
    flag("R9 irq disabled", irq, 1'b0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule